// File: doc/BRIEF.md
# Horizontal Video Timing Analyzer

This block measures the horizontal timing of an incoming video signal so that a monitor controller can size and centre the picture on its own. It watches three inputs that arrive with no fixed relation to its clock: the horizontal sync, the horizontal flyback pulse and an active-video indication. It counts the intervals between their edges in periods of a fast measurement clock, which is 40/3 of the crystal frequency in the intended system. Six 12-bit results come out.

A measurement is armed by a one-cycle start pulse from the host side. It begins at the first rising sync edge that arrives while the trigger-line input is high, which marks the programmed scan line. It then runs over a parameterised number of lines. When the last sync edge of the window arrives, all six results are updated in the same cycle and a done flag is raised. The results keep their values until the next measurement completes. Two of the results hold the smallest interval seen over the window. The other four hold the most recent value.

Top module: `hta_top`

## Requirements
- R1: After reset all six result outputs read 0 and `done_o` is low.
- R2: `res_h3_o` holds the line period: the count from one rising sync edge to the next.
- R3: `res_h1_o` holds the minimum, over the lines of the window, of the count from the rising sync edge to the rising edge of active video.
- R4: `res_h2_o` holds the minimum, over the window, of the count from the falling edge of active video to the next rising sync edge.
- R5: `res_h4_o` holds the count from the rising flyback edge to the following rising sync edge, taken on the last line of the window.
- R6: `res_h5_o` holds the count from the rising sync edge to the falling flyback edge, taken on the last line of the window.
- R7: `res_h6_o` holds the flyback pulse width, from its rising edge to its falling edge. Pulses as narrow as 2 counts are measured exactly.
- R8: A measurement starts only at a rising sync edge that is seen while armed and while `trig_line_i` is high. Without the trigger line, a start pulse leaves the results and `done_o` unchanged.
- R9: A measurement spans `LINES` rising sync edges after its first one. At the end of the window, all six results load together and `done_o` rises. `start_i` clears `done_o` on the next cycle. Between completions the results keep their values.
- R10: Every count saturates at 4095 (0xFFF) and does not wrap. A line longer than 4095 clocks reads 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Measurement clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that arms a measurement and clears done |
| trig_line_i | input | 1 | High while the programmed trigger line is current (synchronous to clk_i) |
| hsync_i | input | 1 | Horizontal sync, positive polarity, asynchronous |
| hfly_i | input | 1 | Horizontal flyback pulse, positive, asynchronous |
| actv_i | input | 1 | Active-video indication, asynchronous |
| res_h1_o | output | 12 | Minimum sync-to-video-start count |
| res_h2_o | output | 12 | Minimum video-end-to-sync count |
| res_h3_o | output | 12 | Line period |
| res_h4_o | output | 12 | Flyback-start-to-sync count |
| res_h5_o | output | 12 | Sync-to-flyback-end count |
| res_h6_o | output | 12 | Flyback width |
| done_o | output | 1 | Set when a measurement completes |

## Verification
The properties assume that `trig_line_i` is already in the clock domain. They also assume that the host does not pulse `start_i` in the same cycle in which it expects a completion. Every line is assumed to carry one sync pulse, and the flyback and active-video pulses are assumed to fall inside that line.

The stimulus builds each line from a sync pulse at offset zero and an active-video pulse whose start and end are drawn at random for each line. The active video always ends before the flyback begins. The flyback straddles the sync edge by fixed amounts. The trigger input is raised for exactly one line, and it is sampled after the two-cycle synchronizer delay, which applies equally to all three video inputs.

// File: rtl/hta_pkg.sv
package hta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2
  } hta_state_e;

  localparam int SIG_HS  = 0;
  localparam int SIG_FLY = 1;
  localparam int SIG_AV  = 2;
  localparam int NSIG    = 3;
endpackage

// File: rtl/hta_sync.sv
// Two-flop synchronizer with one extra stage for edge detection.
module hta_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] cur_o,
  output logic [N-1:0] prv_o
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign cur_o = s2_q;
  assign prv_o = s3_q;
endmodule

// File: rtl/hta_sat_cnt.sv
// Interval counter: restarts at 1 on an event, otherwise counts up to all-ones and holds.
module hta_sat_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CMAX = '1;
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)          cnt_d = W'(1);
    else if (cnt_q != CMAX) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= CMAX;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hta_min_trk.sv
// Running minimum; nxt_o exposes the value including this cycle's update.
module hta_min_trk #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         upd_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W-1:0] CMAX = '1;
  logic [W-1:0] min_q, min_d;

  always_comb begin
    min_d = min_q;
    if (clear_i)                     min_d = CMAX;
    else if (upd_i && val_i < min_q) min_d = val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) min_q <= CMAX;
    else         min_q <= min_d;
  end

  assign nxt_o = min_d;
endmodule

// File: rtl/hta_top.sv
module hta_top
  import hta_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int LINES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trig_line_i,
  input  logic             hsync_i,
  input  logic             hfly_i,
  input  logic             actv_i,
  output logic [CNT_W-1:0] res_h1_o,
  output logic [CNT_W-1:0] res_h2_o,
  output logic [CNT_W-1:0] res_h3_o,
  output logic [CNT_W-1:0] res_h4_o,
  output logic [CNT_W-1:0] res_h5_o,
  output logic [CNT_W-1:0] res_h6_o,
  output logic             done_o
);
  localparam int               LN_W = $clog2(LINES + 1);
  localparam logic [LN_W-1:0]  LAST = LN_W'(LINES - 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  // synchronized inputs and edges
  logic [NSIG-1:0] sig_cur, sig_prv;
  hta_sync #(.N(NSIG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({actv_i, hfly_i, hsync_i}),
    .cur_o (sig_cur),
    .prv_o (sig_prv)
  );

  logic hs_rise, fly_rise, fly_fall, av_rise, av_fall;
  assign hs_rise  =  sig_cur[SIG_HS]  & ~sig_prv[SIG_HS];
  assign fly_rise =  sig_cur[SIG_FLY] & ~sig_prv[SIG_FLY];
  assign fly_fall = ~sig_cur[SIG_FLY] &  sig_prv[SIG_FLY];
  assign av_rise  =  sig_cur[SIG_AV]  & ~sig_prv[SIG_AV];
  assign av_fall  = ~sig_cur[SIG_AV]  &  sig_prv[SIG_AV];

  // interval counters
  logic [CNT_W-1:0] pos_cnt, fly_cnt, avend_cnt;
  hta_sat_cnt #(.W(CNT_W)) u_cnt_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(hs_rise), .cnt_o(pos_cnt));
  hta_sat_cnt #(.W(CNT_W)) u_cnt_fly (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(fly_rise), .cnt_o(fly_cnt));
  hta_sat_cnt #(.W(CNT_W)) u_cnt_avend (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(av_fall), .cnt_o(avend_cnt));

  // control
  hta_state_e      state_q, state_d;
  logic [LN_W-1:0] lines_q, lines_d;
  logic            clr_win, commit, run_w;

  assign run_w = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    lines_d = lines_q;
    clr_win = 1'b0;
    commit  = 1'b0;
    if (start_i) begin
      state_d = ST_ARMED;
    end else begin
      unique case (state_q)
        ST_ARMED: if (hs_rise && trig_line_i) begin
          state_d = ST_RUN;
          lines_d = '0;
          clr_win = 1'b1;
        end
        ST_RUN: if (hs_rise) begin
          lines_d = lines_q + LN_W'(1);
          if (lines_q == LAST) begin
            commit  = 1'b1;
            state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lines_q <= '0;
    end else begin
      state_q <= state_d;
      lines_q <= lines_d;
    end
  end

  // window captures
  logic cap_hs, cap_ff, cap_ar;
  assign cap_hs = run_w & hs_rise;
  assign cap_ff = run_w & fly_fall;
  assign cap_ar = run_w & av_rise;

  logic [CNT_W-1:0] h1_nxt, h2_nxt;
  hta_min_trk #(.W(CNT_W)) u_min_h1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clr_win),
    .upd_i(cap_ar), .val_i(pos_cnt), .nxt_o(h1_nxt));
  hta_min_trk #(.W(CNT_W)) u_min_h2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clr_win),
    .upd_i(cap_hs), .val_i(avend_cnt), .nxt_o(h2_nxt));

  logic [CNT_W-1:0] sh3_q, sh4_q, sh5_q, sh6_q;
  logic [CNT_W-1:0] sh3_d, sh4_d, sh5_d, sh6_d;

  always_comb begin
    sh3_d = sh3_q;
    sh4_d = sh4_q;
    sh5_d = sh5_q;
    sh6_d = sh6_q;
    if (clr_win) begin
      sh3_d = CMAX;
      sh4_d = CMAX;
      sh5_d = CMAX;
      sh6_d = CMAX;
    end else begin
      if (cap_hs) begin
        sh3_d = pos_cnt;
        sh4_d = fly_cnt;
      end
      if (cap_ff) begin
        sh5_d = pos_cnt;
        sh6_d = fly_cnt;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh3_q <= CMAX;
      sh4_q <= CMAX;
      sh5_q <= CMAX;
      sh6_q <= CMAX;
    end else begin
      sh3_q <= sh3_d;
      sh4_q <= sh4_d;
      sh5_q <= sh5_d;
      sh6_q <= sh6_d;
    end
  end

  // result registers, loaded together on commit
  logic done_d;
  always_comb begin
    done_d = done_o;
    if (start_i)     done_d = 1'b0;
    else if (commit) done_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_h1_o <= '0;
      res_h2_o <= '0;
      res_h3_o <= '0;
      res_h4_o <= '0;
      res_h5_o <= '0;
      res_h6_o <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= done_d;
      if (commit) begin
        res_h1_o <= h1_nxt;
        res_h2_o <= h2_nxt;
        res_h3_o <= sh3_d;
        res_h4_o <= sh4_d;
        res_h5_o <= sh5_d;
        res_h6_o <= sh6_d;
      end
    end
  end
endmodule

// File: rtl/hta_top_chk.sv
module hta_top_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             trig_line_i,
  input logic             run_i,
  input logic             done_i,
  input logic [CNT_W-1:0] h1_i,
  input logic [CNT_W-1:0] h2_i,
  input logic [CNT_W-1:0] h3_i,
  input logic [CNT_W-1:0] h4_i,
  input logic [CNT_W-1:0] h5_i,
  input logic [CNT_W-1:0] h6_i
);
  // R9: a start pulse clears done on the following cycle
  p_done_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_i);

  // R9: results change only in the cycle done rises
  p_results_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_i) |-> ($stable(h1_i) && $stable(h2_i) && $stable(h3_i) &&
                        $stable(h4_i) && $stable(h5_i) && $stable(h6_i)));

  // R9: completion only follows a running window
  p_commit_from_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(run_i));

  // R8: the window opens only while the trigger line is high
  p_run_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> $past(trig_line_i));

  // R2: a completed line period is never zero
  p_period_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> (h3_i != '0));
endmodule

bind hta_top hta_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .trig_line_i(trig_line_i),
  .run_i      (run_w),
  .done_i     (done_o),
  .h1_i       (res_h1_o),
  .h2_i       (res_h2_o),
  .h3_i       (res_h3_o),
  .h4_i       (res_h4_o),
  .h5_i       (res_h5_o),
  .h6_i       (res_h6_o)
);

// File: tb/hta_top_bench.sv
module hta_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL         = 4;
  localparam int TL         = 1;   // trigger line index within a run

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        start_i, trig_line_i, hsync_i, hfly_i, actv_i;
  logic [11:0] res_h1_o, res_h2_o, res_h3_o, res_h4_o, res_h5_o, res_h6_o;
  logic        done_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  int av_a [0:15];
  int av_e [0:15];
  logic [11:0] prev [0:5];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hta_top #(.CNT_W(12), .LINES(NL)) u_hta_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .trig_line_i(trig_line_i),
    .hsync_i(hsync_i), .hfly_i(hfly_i), .actv_i(actv_i),
    .res_h1_o(res_h1_o), .res_h2_o(res_h2_o), .res_h3_o(res_h3_o),
    .res_h4_o(res_h4_o), .res_h5_o(res_h5_o), .res_h6_o(res_h6_o),
    .done_o(done_o)
  );

  function automatic logic [11:0] sat12(input int v);
    return (v > 4095) ? 12'hFFF : 12'(v);
  endfunction

  function automatic int min_start();
    int m = 1 << 20;
    for (int k = TL; k < TL + NL; k++) if (av_a[k] < m) m = av_a[k];
    return m;
  endfunction

  function automatic int min_end(input int p);
    int m = 1 << 20;
    for (int k = TL; k < TL + NL; k++) if (p - av_e[k] < m) m = p - av_e[k];
    return m;
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic save_prev();
    prev[0] = res_h1_o; prev[1] = res_h2_o; prev[2] = res_h3_o;
    prev[3] = res_h4_o; prev[4] = res_h5_o; prev[5] = res_h6_o;
  endtask

  task automatic chk_unchanged(input string req);
    chk({req, " h1 held"}, res_h1_o, prev[0]);
    chk({req, " h2 held"}, res_h2_o, prev[1]);
    chk({req, " h3 held"}, res_h3_o, prev[2]);
    chk({req, " h4 held"}, res_h4_o, prev[3]);
    chk({req, " h5 held"}, res_h5_o, prev[4]);
    chk({req, " h6 held"}, res_h6_o, prev[5]);
  endtask

  // Drive nl lines of period p; start pulse at line 0, trigger during line TL.
  task automatic run_lines(input int p, input int w, input int d4, input int d5,
                           input bit use_trig, input int nl, input bit hold_chk);
    for (int k = 0; k < nl; k++) begin
      av_a[k] = w + 1 + int'($urandom % 40);
      av_e[k] = p - d4 - 2 - int'($urandom % 8);
    end
    for (int k = 0; k < nl; k++) begin
      for (int pos = 0; pos < p; pos++) begin
        @(negedge clk_i);
        hsync_i     = (pos < w);
        hfly_i      = (pos < d5) || (pos >= p - d4);
        actv_i      = (pos >= av_a[k]) && (pos < av_e[k]);
        start_i     = (k == 0) && (pos == 0);
        trig_line_i = use_trig && (k == TL);
        if (hold_chk && k == 0 && pos == p - 1) begin
          chk("R9 done cleared by start", {11'd0, done_o}, 12'd0);
          chk_unchanged("R9");
        end
      end
    end
    @(negedge clk_i);
    hsync_i = 0; hfly_i = 0; actv_i = 0; start_i = 0; trig_line_i = 0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic measure(input string tag, input int p, input int w,
                         input int d4, input int d5, input bit hold_chk);
    save_prev();
    run_lines(p, w, d4, d5, 1'b1, TL + NL + 1, hold_chk);
    chk({tag, " R9 done"}, {11'd0, done_o}, 12'd1);
    chk({tag, " R3 h1"}, res_h1_o, sat12(min_start()));
    chk({tag, " R4 h2"}, res_h2_o, sat12(min_end(p)));
    chk({tag, " R2 h3"}, res_h3_o, sat12(p));
    chk({tag, " R5 h4"}, res_h4_o, sat12(d4));
    chk({tag, " R6 h5"}, res_h5_o, sat12(d5));
    chk({tag, " R7 h6"}, res_h6_o, sat12(d4 + d5));
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 0; start_i = 0; trig_line_i = 0; hsync_i = 0; hfly_i = 0; actv_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 h1", res_h1_o, 12'd0);
    chk("R1 h2", res_h2_o, 12'd0);
    chk("R1 h3", res_h3_o, 12'd0);
    chk("R1 h4", res_h4_o, 12'd0);
    chk("R1 h5", res_h5_o, 12'd0);
    chk("R1 h6", res_h6_o, 12'd0);
    chk("R1 done", {11'd0, done_o}, 12'd0);

    // directed nominal line
    measure("nominal", 300, 20, 10, 30, 1'b1);

    // random line shapes, hold checked during each new run
    for (int i = 0; i < 3; i++) begin
      int p, w, d4, d5;
      p  = 200 + int'($urandom % 400);
      w  = 4 + int'($urandom % 20);
      d4 = 1 + int'($urandom % 30);
      d5 = 1 + int'($urandom % 30);
      measure("random", p, w, d4, d5, 1'b1);
    end

    // narrowest flyback: width 2 (R7)
    measure("narrow R7", 150, 6, 1, 1, 1'b0);

    // start without trigger line (R8)
    save_prev();
    run_lines(200, 10, 5, 5, 1'b0, 4, 1'b0);
    chk("R8 no trigger done", {11'd0, done_o}, 12'd0);
    chk_unchanged("R8 no trigger");

    // overlong line saturates (R10)
    measure("long R10", 4200, 30, 12, 25, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule